// File: doc/BRIEF.md
# Test-port translation lookaside buffer

This block is a small set-associative translation cache that maps 20-bit linear page numbers to 20-bit physical page numbers. It holds four ways of eight sets. Each entry keeps a linear tag, a valid flag, three attribute flags (dirty, user, writable) and a physical page number. Software reaches the entries only through a pair of test registers. A command word carries the operation, the linear page number, the valid flag and one true/complement pair per attribute. A data register carries the physical page number, a hit flag and a way number.

A write command builds an entry from the command word and the data register, and places it in the way that the data register names. A lookup command compares the command word with the four entries of the addressed set. It records the outcome in the data register on the following clock. Each attribute pair is a match mask on lookup and a set value on write. The valid flag is compared like one more address bit. A flush strobe invalidates every entry in one cycle.

Top module: `tlb_testport`

## Requirements
- R1: After reset the data register outputs are all zero and every entry is invalid, so a lookup with valid flag 1 misses.
- R2: A write command (`cmd_op_i` = 0) fills the entry of set `lpn[2:0]` in way `dreg_way_o`. The entry stores tag `lpn[19:3]`, valid flag `cmd_v_i` and physical page `dreg_ppn_o`. The data register outputs do not change because of a write.
- R3: On a write, each attribute pair sets the stored flag: pair 2'b10 stores 1, pair 2'b01 stores 0, and pairs 2'b00 and 2'b11 keep the stored flag. `cmd_pairs_i[5:4]` belongs to dirty, `[3:2]` to user and `[1:0]` to writable. In each pair, bit 1 is the true bit and bit 0 is the complement.
- R4: On a lookup, pair 2'b10 matches only a stored 1, pair 2'b01 matches only a stored 0, and pairs 2'b00 and 2'b11 match either value.
- R5: A lookup compares the stored valid flag with `cmd_v_i` as an address bit. A lookup with valid flag 0 can therefore hit an invalidated entry, and a lookup with valid flag 1 cannot.
- R6: When exactly one way matches, the cycle after the lookup shows `dreg_hit_o` = 1, the entry's physical page on `dreg_ppn_o`, its way on `dreg_way_o` and its flags on `dreg_attr_o` as {dirty, user, writable}.
- R7: When no way or more than one way matches, `dreg_hit_o` is 0 on the cycle after the lookup.
- R8: A flush clears every valid flag. Tags, physical pages and attributes are kept.
- R9: A load (`dreg_we_i`) sets the physical page, the way and the hit flag from the inputs on the next cycle. If a lookup is issued in the same cycle, the lookup result takes priority.
- R10: The data register outputs hold their values in every cycle without a lookup or a load.
- R11: Set selection uses `lpn[2:0]`. The same upper bits in another set address a different entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| dreg_we_i | input | 1 | Load the data register |
| dreg_ppn_i | input | 20 | Physical page number to load |
| dreg_way_i | input | 2 | Way number to load |
| dreg_hit_i | input | 1 | Hit flag to load |
| cmd_valid_i | input | 1 | Issue a command this cycle |
| cmd_op_i | input | 1 | 0 = write, 1 = lookup |
| cmd_lpn_i | input | 20 | Linear page number |
| cmd_v_i | input | 1 | Valid flag to write or to compare |
| cmd_pairs_i | input | 6 | Attribute true/complement pairs {dirty, user, writable} |
| dreg_ppn_o | output | 20 | Data register physical page number |
| dreg_way_o | output | 2 | Data register way number |
| dreg_hit_o | output | 1 | Data register hit flag |
| dreg_attr_o | output | 3 | Attribute flags of the last hit entry |

## Verification
The assertions assume that flush, load and command inputs are known after reset. They also assume that the bench never issues a write and a flush in the same cycle. The property for a single hit relies on the reported way pointing at a matching entry. Duplicate tags in one set are legal only as a case that the block must report as a miss. The stimulus drives every input on the falling edge and holds each command for exactly one cycle. It creates duplicate tags only on purpose, in order to test the rule that several matches give a miss.

// File: rtl/tlb_testport_pkg.sv
package tlb_testport_pkg;

  typedef enum logic {
    CMD_WRITE  = 1'b0,
    CMD_LOOKUP = 1'b1
  } cmd_e;

  localparam int ATTR_N = 3;   // {dirty, user, writable}

  // One true/complement pair against one stored flag: lookup acceptance.
  function automatic logic pair_accepts(input logic [1:0] pair, input logic stored);
    case (pair)
      2'b10:   pair_accepts = stored;
      2'b01:   pair_accepts = !stored;
      default: pair_accepts = 1'b1;
    endcase
  endfunction

  // One pair applied to one stored flag on a write.
  function automatic logic pair_update(input logic [1:0] pair, input logic stored);
    case (pair)
      2'b10:   pair_update = 1'b1;
      2'b01:   pair_update = 1'b0;
      default: pair_update = stored;
    endcase
  endfunction

  function automatic logic attr_accepts(input logic [2*ATTR_N-1:0] pairs,
                                        input logic [ATTR_N-1:0]   attr);
    attr_accepts = 1'b1;
    for (int i = 0; i < ATTR_N; i++)
      attr_accepts = attr_accepts & pair_accepts(pairs[2*i +: 2], attr[i]);
  endfunction

  function automatic logic [ATTR_N-1:0] attr_update(input logic [2*ATTR_N-1:0] pairs,
                                                    input logic [ATTR_N-1:0]   attr);
    for (int i = 0; i < ATTR_N; i++)
      attr_update[i] = pair_update(pairs[2*i +: 2], attr[i]);
  endfunction

endpackage

// File: rtl/tlb_testport_way.sv
module tlb_testport_way
  import tlb_testport_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 17,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  v_i,
  input  logic [2*ATTR_N-1:0]   pairs_i,
  input  logic [PPN_W-1:0]      ppn_i,
  output logic                  match_o,
  output logic [PPN_W-1:0]      ppn_o,
  output logic [ATTR_N-1:0]     attr_o
);

  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [ATTR_N-1:0] attr_q [SETS];
  logic [PPN_W-1:0]  ppn_q  [SETS];
  logic [SETS-1:0]   v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        attr_q[s] <= '0;
        ppn_q[s]  <= '0;
      end
    end else if (flush_i) begin
      v_q <= '0;
    end else if (wr_en_i) begin
      tag_q[idx_i]  <= tag_i;
      v_q[idx_i]    <= v_i;
      attr_q[idx_i] <= attr_update(pairs_i, attr_q[idx_i]);
      ppn_q[idx_i]  <= ppn_i;
    end
  end

  // Valid flag takes part in the compare like an address bit.
  assign match_o = (tag_q[idx_i] == tag_i) && (v_q[idx_i] == v_i) &&
                   attr_accepts(pairs_i, attr_q[idx_i]);
  assign ppn_o   = ppn_q[idx_i];
  assign attr_o  = attr_q[idx_i];

endmodule

// File: rtl/tlb_testport_pick.sv
module tlb_testport_pick
  import tlb_testport_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int PPN_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]              match_i,
  input  logic [WAYS-1:0][PPN_W-1:0]   ppn_i,
  input  logic [WAYS-1:0][ATTR_N-1:0]  attr_i,
  output logic                         hit_o,
  output logic [WAY_W-1:0]             way_o,
  output logic [PPN_W-1:0]             ppn_o,
  output logic [ATTR_N-1:0]            attr_o
);

  // A hit needs exactly one matching way; the merged fields are only
  // meaningful then.
  always_comb begin
    hit_o  = ($countones(match_i) == 1);
    way_o  = '0;
    ppn_o  = '0;
    attr_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match_i[w]) way_o = way_o | WAY_W'(w);
      ppn_o  = ppn_o  | ({PPN_W{match_i[w]}}  & ppn_i[w]);
      attr_o = attr_o | ({ATTR_N{match_i[w]}} & attr_i[w]);
    end
  end

endmodule

// File: rtl/tlb_testport.sv
module tlb_testport
  import tlb_testport_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int LPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = LPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush_i,
  input  logic                 dreg_we_i,
  input  logic [PPN_W-1:0]     dreg_ppn_i,
  input  logic [WAY_W-1:0]     dreg_way_i,
  input  logic                 dreg_hit_i,
  input  logic                 cmd_valid_i,
  input  logic                 cmd_op_i,
  input  logic [LPN_W-1:0]     cmd_lpn_i,
  input  logic                 cmd_v_i,
  input  logic [2*ATTR_N-1:0]  cmd_pairs_i,
  output logic [PPN_W-1:0]     dreg_ppn_o,
  output logic [WAY_W-1:0]     dreg_way_o,
  output logic                 dreg_hit_o,
  output logic [ATTR_N-1:0]    dreg_attr_o
);

  // Named internal events, observed by the bound checker.
  logic wr_fire;   // R2: write command accepted
  logic lk_fire;   // R6/R7: lookup command accepted
  logic [WAYS-1:0]             match_vec;
  logic [WAYS-1:0][PPN_W-1:0]  way_ppn;
  logic [WAYS-1:0][ATTR_N-1:0] way_attr;
  logic                        res_hit;
  logic [WAY_W-1:0]            res_way;
  logic [PPN_W-1:0]            res_ppn;
  logic [ATTR_N-1:0]           res_attr;

  assign wr_fire = cmd_valid_i && (cmd_e'(cmd_op_i) == CMD_WRITE) && !flush_i;
  assign lk_fire = cmd_valid_i && (cmd_e'(cmd_op_i) == CMD_LOOKUP);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_testport_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .wr_en_i (wr_fire && (dreg_way_o == WAY_W'(w))),
      .idx_i   (cmd_lpn_i[IDX_W-1:0]),     // R11: set index
      .tag_i   (cmd_lpn_i[LPN_W-1:IDX_W]),
      .v_i     (cmd_v_i),
      .pairs_i (cmd_pairs_i),
      .ppn_i   (dreg_ppn_o),
      .match_o (match_vec[w]),
      .ppn_o   (way_ppn[w]),
      .attr_o  (way_attr[w])
    );
  end

  tlb_testport_pick #(
    .WAYS  (WAYS),
    .PPN_W (PPN_W)
  ) u_pick (
    .match_i (match_vec),
    .ppn_i   (way_ppn),
    .attr_i  (way_attr),
    .hit_o   (res_hit),
    .way_o   (res_way),
    .ppn_o   (res_ppn),
    .attr_o  (res_attr)
  );

  // Data register: a lookup result wins over a load in the same cycle (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg_ppn_o  <= '0;
      dreg_way_o  <= '0;
      dreg_hit_o  <= 1'b0;
      dreg_attr_o <= '0;
    end else if (lk_fire) begin
      dreg_hit_o <= res_hit;
      if (res_hit) begin
        dreg_ppn_o  <= res_ppn;
        dreg_way_o  <= res_way;
        dreg_attr_o <= res_attr;
      end
    end else if (dreg_we_i) begin
      dreg_ppn_o <= dreg_ppn_i;
      dreg_way_o <= dreg_way_i;
      dreg_hit_o <= dreg_hit_i;
    end
  end

endmodule

// File: rtl/tlb_testport_chk.sv
module tlb_testport_chk #(
  parameter int WAYS  = 4,
  parameter int PPN_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             dreg_we_i,
  input logic [PPN_W-1:0] dreg_ppn_i,
  input logic [WAY_W-1:0] dreg_way_i,
  input logic             dreg_hit_i,
  input logic             cmd_v_i,
  input logic             lk_fire,
  input logic [WAYS-1:0]  match_vec,
  input logic [PPN_W-1:0] dreg_ppn_o,
  input logic [WAY_W-1:0] dreg_way_o,
  input logic             dreg_hit_o
);

  logic [WAYS-1:0] match_q;
  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= '0;
    else        match_q <= match_vec;
  end

  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire && ($countones(match_vec) == 1) |=> dreg_hit_o && match_q[dreg_way_o]);

  p_plural_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire && ($countones(match_vec) != 1) |=> !dreg_hit_o);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire && !dreg_we_i |=> $stable(dreg_hit_o) && $stable(dreg_way_o) && $stable(dreg_ppn_o));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dreg_we_i && !lk_fire |=> (dreg_ppn_o == $past(dreg_ppn_i)) &&
                              (dreg_way_o == $past(dreg_way_i)) &&
                              (dreg_hit_o == $past(dreg_hit_i)));

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) && lk_fire && cmd_v_i |-> (match_vec == '0));

endmodule

bind tlb_testport tlb_testport_chk #(
  .WAYS  (WAYS),
  .PPN_W (PPN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .dreg_we_i  (dreg_we_i),
  .dreg_ppn_i (dreg_ppn_i),
  .dreg_way_i (dreg_way_i),
  .dreg_hit_i (dreg_hit_i),
  .cmd_v_i    (cmd_v_i),
  .lk_fire    (lk_fire),
  .match_vec  (match_vec),
  .dreg_ppn_o (dreg_ppn_o),
  .dreg_way_o (dreg_way_o),
  .dreg_hit_o (dreg_hit_o)
);

// File: tb/tlb_testport_tb.sv
`timescale 1ns/1ps
module tlb_testport_tb;

  localparam logic [1:0] OP_WR = 2'd0, OP_LK = 2'd1, OP_FL = 2'd2;
  localparam logic [1:0] PO = 2'b10, PZ = 2'b01, PX = 2'b00, PY = 2'b11;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] lpn;
    logic        v;
    logic [5:0]  pairs;
    logic [19:0] ppn;
    logic [1:0]  way;
    logic        hit;
    logic [2:0]  attr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{OP_LK, 20'h00000, 1'b1, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd1},  // R1
    '{OP_WR, 20'h12345, 1'b1, {PO,PZ,PO}, 20'hAAAA1, 2'd0, 1'b0, 3'b000, 4'd2},  // R2
    '{OP_WR, 20'h22345, 1'b1, {PZ,PO,PZ}, 20'hBBBB2, 2'd1, 1'b0, 3'b000, 4'd2},
    '{OP_WR, 20'h32345, 1'b1, {PO,PO,PO}, 20'hCCCC3, 2'd2, 1'b0, 3'b000, 4'd2},
    '{OP_WR, 20'h42345, 1'b1, {PZ,PZ,PZ}, 20'hDDDD4, 2'd3, 1'b0, 3'b000, 4'd2},
    '{OP_LK, 20'h12345, 1'b1, {PX,PX,PX}, 20'hAAAA1, 2'd0, 1'b1, 3'b101, 4'd6},  // R6
    '{OP_LK, 20'h22345, 1'b1, {PX,PX,PX}, 20'hBBBB2, 2'd1, 1'b1, 3'b010, 4'd6},
    '{OP_LK, 20'h32345, 1'b1, {PX,PX,PX}, 20'hCCCC3, 2'd2, 1'b1, 3'b111, 4'd6},
    '{OP_LK, 20'h42345, 1'b1, {PY,PY,PY}, 20'hDDDD4, 2'd3, 1'b1, 3'b000, 4'd4},  // R4
    '{OP_LK, 20'h12345, 1'b1, {PO,PX,PX}, 20'hAAAA1, 2'd0, 1'b1, 3'b101, 4'd4},
    '{OP_LK, 20'h12345, 1'b1, {PZ,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd4},
    '{OP_LK, 20'h12345, 1'b1, {PX,PZ,PX}, 20'hAAAA1, 2'd0, 1'b1, 3'b101, 4'd4},
    '{OP_LK, 20'h12345, 1'b1, {PX,PO,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd4},
    '{OP_LK, 20'h12345, 1'b1, {PX,PX,PO}, 20'hAAAA1, 2'd0, 1'b1, 3'b101, 4'd4},
    '{OP_LK, 20'h12345, 1'b1, {PX,PX,PZ}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd4},
    '{OP_LK, 20'h12346, 1'b1, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd11}, // R11
    '{OP_LK, 20'h12345, 1'b0, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd5},  // R5
    '{OP_WR, 20'h12345, 1'b1, {PX,PY,PZ}, 20'hEEEE5, 2'd0, 1'b0, 3'b000, 4'd3},  // R3
    '{OP_LK, 20'h12345, 1'b1, {PX,PX,PX}, 20'hEEEE5, 2'd0, 1'b1, 3'b100, 4'd3},
    '{OP_WR, 20'h22345, 1'b1, {PZ,PZ,PZ}, 20'h11111, 2'd2, 1'b0, 3'b000, 4'd7},
    '{OP_LK, 20'h22345, 1'b1, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd7},  // R7
    '{OP_LK, 20'h22345, 1'b1, {PX,PO,PX}, 20'hBBBB2, 2'd1, 1'b1, 3'b010, 4'd7},
    '{OP_FL, 20'h00000, 1'b0, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd8},  // R8
    '{OP_LK, 20'h42345, 1'b1, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd8},
    '{OP_LK, 20'h42345, 1'b0, {PX,PX,PX}, 20'hDDDD4, 2'd3, 1'b1, 3'b000, 4'd8},
    '{OP_LK, 20'h00000, 1'b0, {PX,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd7},
    '{OP_LK, 20'h00007, 1'b0, {PO,PX,PX}, 20'h0,     2'd0, 1'b0, 3'b000, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        dreg_we_i = 1'b0;
  logic [19:0] dreg_ppn_i = '0;
  logic [1:0]  dreg_way_i = '0;
  logic        dreg_hit_i = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_op_i = 1'b0;
  logic [19:0] cmd_lpn_i = '0;
  logic        cmd_v_i = 1'b0;
  logic [5:0]  cmd_pairs_i = '0;
  logic [19:0] dreg_ppn_o;
  logic [1:0]  dreg_way_o;
  logic        dreg_hit_o;
  logic [2:0]  dreg_attr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlb_testport u_dut (
    .clk, .rst_n, .flush_i, .dreg_we_i, .dreg_ppn_i, .dreg_way_i, .dreg_hit_i,
    .cmd_valid_i, .cmd_op_i, .cmd_lpn_i, .cmd_v_i, .cmd_pairs_i,
    .dreg_ppn_o, .dreg_way_o, .dreg_hit_o, .dreg_attr_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_dreg(input logic [19:0] ppn, input logic [1:0] way, input logic hit);
    @(negedge clk);
    dreg_we_i = 1'b1; dreg_ppn_i = ppn; dreg_way_i = way; dreg_hit_i = hit;
    @(negedge clk);
    dreg_we_i = 1'b0;
  endtask

  task automatic issue(input logic op, input logic [19:0] lpn, input logic v,
                       input logic [5:0] pairs);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_lpn_i = lpn; cmd_v_i = v; cmd_pairs_i = pairs;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t t);
    string rq;
    rq = $sformatf("R%0d", t.req);
    case (t.op)
      OP_WR: begin
        load_dreg(t.ppn, t.way, 1'b1);
        issue(1'b0, t.lpn, t.v, t.pairs);
      end
      OP_FL: begin
        @(negedge clk); flush_i = 1'b1;
        @(negedge clk); flush_i = 1'b0;
      end
      default: begin
        issue(1'b1, t.lpn, t.v, t.pairs);
        check(dreg_hit_o == t.hit, rq, "hit", 32'(dreg_hit_o), 32'(t.hit));
        if (t.hit) begin
          check(dreg_ppn_o == t.ppn, rq, "ppn", 32'(dreg_ppn_o), 32'(t.ppn));
          check(dreg_way_o == t.way, rq, "way", 32'(dreg_way_o), 32'(t.way));
          check(dreg_attr_o == t.attr, rq, "attr", 32'(dreg_attr_o), 32'(t.attr));
        end
      end
    endcase
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [19:0] p0;
    logic [1:0]  w0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dreg_hit_o == 1'b0 && dreg_ppn_o == '0 && dreg_way_o == '0 && dreg_attr_o == '0,
          "R1", "reset outputs", {9'd0, dreg_attr_o, dreg_way_o, dreg_hit_o, dreg_ppn_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: load is visible on the next cycle
    load_dreg(20'h5A5A5, 2'd2, 1'b0);
    check(dreg_ppn_o == 20'h5A5A5 && dreg_way_o == 2'd2 && !dreg_hit_o, "R9", "load",
          {9'd0, 3'd0, dreg_way_o, dreg_hit_o, dreg_ppn_o}, {9'd0, 3'd0, 2'd2, 1'b0, 20'h5A5A5});
    // R10: idle cycles keep the register
    repeat (3) @(negedge clk);
    check(dreg_ppn_o == 20'h5A5A5 && dreg_way_o == 2'd2, "R10", "idle hold",
          32'(dreg_ppn_o), 32'h5A5A5);
    // R2: a write leaves the data register alone
    issue(1'b0, 20'h77777, 1'b1, {PX,PX,PX});
    check(dreg_ppn_o == 20'h5A5A5 && dreg_way_o == 2'd2 && !dreg_hit_o, "R2", "write keeps dreg",
          32'(dreg_ppn_o), 32'h5A5A5);
    // R2: entry written from the data register, way 2 of set 7, reset flags
    issue(1'b1, 20'h77777, 1'b1, {PX,PX,PX});
    check(dreg_hit_o && dreg_ppn_o == 20'h5A5A5 && dreg_way_o == 2'd2 && dreg_attr_o == 3'b000,
          "R2", "written entry", {9'd0, dreg_attr_o, dreg_way_o, dreg_hit_o, dreg_ppn_o},
          {9'd0, 3'd0, 2'd2, 1'b1, 20'h5A5A5});
    // R9: lookup and load together, lookup wins
    load_dreg(20'h33333, 2'd1, 1'b0);
    @(negedge clk);
    dreg_we_i = 1'b1; dreg_ppn_i = 20'h0F0F0; dreg_way_i = 2'd3; dreg_hit_i = 1'b0;
    cmd_valid_i = 1'b1; cmd_op_i = 1'b1; cmd_lpn_i = 20'h77777; cmd_v_i = 1'b1; cmd_pairs_i = '0;
    @(negedge clk);
    dreg_we_i = 1'b0; cmd_valid_i = 1'b0;
    p0 = dreg_ppn_o; w0 = dreg_way_o;
    check(dreg_hit_o && p0 == 20'h5A5A5 && w0 == 2'd2, "R9", "lookup priority",
          32'(p0), 32'h5A5A5);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule